// File: doc/BRIEF.md
# Byte Accumulator Arithmetic Unit with Nibble Flags

This block is the purely combinational arithmetic and logic stage of an 8-bit accumulator datapath. It takes a 5-bit operation code, an accumulator operand, a second byte operand, a pair of 16-bit operands for the wide add, and the current 4-bit flag vector. In the same cycle it returns the new byte result, the wide sum and the next flag vector. The surrounding core owns the register file, instruction decode and memory traffic. It writes back whichever result the instruction selects, and it always writes back the flag vector.

Each operation has its own rule for every flag. The rule may compute the flag from the data, force it to a fixed value, or pass the incoming value through unchanged. The half-carry flag comes from the low nibble on byte operations and from bit 11 on the wide add. There are no registers and no control states. The operation code alone selects one of a set of named behaviours through a single case over the operation enumeration.

Top module: `alu8_core`

## Requirements
- R1: The flag vector is {Z,N,H,C} at bits 3,2,1,0. The operation codes are ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, AND=5, OR=6, XOR=7, INC=8, DEC=9, RLC=10, RRC=11, RLT=12, RRT=13, CPL=14, SCF=15, CCF=16 and WADD=17.
- R2: ADD and ADC return (a+b+cin) mod 256, with cin = incoming C for ADC and 0 for ADD. They clear N, set Z when the byte result is 0, set C when the 9-bit sum exceeds 255, and set H when a[3:0]+b[3:0]+cin exceeds 15.
- R3: SUB and SBC return (a-b-cin) mod 256, with cin = incoming C for SBC and 0 for SUB. They set N, set Z when the result is 0, set C when a < b+cin, and set H when a[3:0] < b[3:0]+cin.
- R4: CMP updates all four flags exactly as SUB does, but res_o stays equal to a_i.
- R5: AND sets H to 1. OR and XOR set H to 0. All three clear N and C and set Z when the result is 0.
- R6: INC and DEC add or subtract one from a_i. They set Z, N and H as ADD or SUB of 1 would, and pass the incoming C through unchanged.
- R7: RLC rotates a_i left by one and RRC rotates it right by one. The bit that leaves goes both into C and into the vacated end. Z, N and H are cleared.
- R8: RLT shifts a_i left with the old C entering bit 0, and RRT shifts it right with the old C entering bit 7. The bit that leaves goes into C. Z, N and H are cleared.
- R9: CPL returns the bitwise inverse of a_i, sets N and H, and leaves Z and C unchanged.
- R10: SCF sets C. CCF inverts C. Both clear N and H and leave Z and the byte result (a_i) unchanged.
- R11: wres_o is always (wa_i+wb_i) mod 65536. For WADD, N is cleared, H is the carry out of bit 11, C is the carry out of bit 15, and Z and res_o (= a_i) are unchanged.
- R12: Codes 18 to 31 return res_o = a_i and leave the flag vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (R1) |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second byte operand |
| wa_i | input | 16 | First wide operand |
| wb_i | input | 16 | Second wide operand |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| res_o | output | 8 | Byte result |
| wres_o | output | 16 | Wide sum |
| flags_o | output | 4 | Next flags {Z,N,H,C} |

## Verification
Directed operands stress the edges of the arithmetic. The values 0x0F/0x01 produce a nibble carry with no byte carry. 0xFF/0x01 produces both carries and a zero result. Equal operands under subtract and compare give a zero result with no borrow. 0x00 minus 0xFF with an incoming carry separates the 9-bit borrow from a byte wrap. For the rotates, alternating bit patterns run against both carry values, which separates the circular forms from the through-carry forms. The wide add is tried at 0x0FFF+0x0001 and at 0xFFFF+0x0001, which separates the bit-11 carry from the bit-15 carry. Randomised operands, covering every code including the unused ones and both carry-in values, then check that each flag is computed, forced or passed through as its rule says.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W = 5;
    localparam int FLAG_W = 4;
    localparam int FZ = 3;
    localparam int FN = 2;
    localparam int FH = 1;
    localparam int FC = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_INC  = 5'd8,
        OP_DEC  = 5'd9,
        OP_RLC  = 5'd10,
        OP_RRC  = 5'd11,
        OP_RLT  = 5'd12,
        OP_RRT  = 5'd13,
        OP_CPL  = 5'd14,
        OP_SCF  = 5'd15,
        OP_CCF  = 5'd16,
        OP_WADD = 5'd17
    } alu_op_e;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              z,
    output logic              n,
    output logic              h,
    output logic              c
);
    logic [DATA_W:0]     full;
    logic [NIB_W:0]      nib;
    logic [DATA_W-1:0]   opnd;
    logic                use_cin;
    logic                sub;
    logic                ci;

    always_comb begin
        sub     = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);
        use_cin = (op == OP_ADC) || (op == OP_SBC);
        ci      = use_cin & cin;
        opnd    = ((op == OP_INC) || (op == OP_DEC)) ? DATA_W'(1) : b;
        if (sub) begin
            full = {1'b0, a} - {1'b0, opnd} - (DATA_W+1)'(ci);
            nib  = {1'b0, a[NIB_W-1:0]} - {1'b0, opnd[NIB_W-1:0]} - (NIB_W+1)'(ci);
        end else begin
            full = {1'b0, a} + {1'b0, opnd} + (DATA_W+1)'(ci);
            nib  = {1'b0, a[NIB_W-1:0]} + {1'b0, opnd[NIB_W-1:0]} + (NIB_W+1)'(ci);
        end
        res = full[DATA_W-1:0];
        c   = full[DATA_W];
        h   = nib[NIB_W];
        z   = (res == '0);
        n   = sub;
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              z
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = ~a;
        endcase
        z = (res == '0);
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        unique case (op)
            OP_RLC: begin
                res  = {a[MSB-1:0], a[MSB]};
                cout = a[MSB];
            end
            OP_RRC: begin
                res  = {a[0], a[MSB:1]};
                cout = a[0];
            end
            OP_RLT: begin
                res  = {a[MSB-1:0], cin};
                cout = a[MSB];
            end
            default: begin
                res  = {cin, a[MSB:1]};
                cout = a[0];
            end
        endcase
    end
endmodule

// File: rtl/alu8_wide_add.sv
module alu8_wide_add #(
    parameter int WIDE_W = 16,
    parameter int NIB_W  = 4
) (
    input  logic [WIDE_W-1:0] wa,
    input  logic [WIDE_W-1:0] wb,
    output logic [WIDE_W-1:0] sum,
    output logic              h,
    output logic              c
);
    localparam int LOW_W = WIDE_W - NIB_W;

    logic [WIDE_W:0] full;
    logic [LOW_W:0]  low;

    always_comb begin
        full = {1'b0, wa} + {1'b0, wb};
        low  = {1'b0, wa[LOW_W-1:0]} + {1'b0, wb[LOW_W-1:0]};
        sum  = full[WIDE_W-1:0];
        c    = full[WIDE_W];
        h    = low[LOW_W];
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4,
    parameter int WIDE_W = 16
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [WIDE_W-1:0] wa_i,
    input  logic [WIDE_W-1:0] wb_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] res_o,
    output logic [WIDE_W-1:0] wres_o,
    output logic [FLAG_W-1:0] flags_o
);
    alu_op_e op;
    assign op = alu_op_e'(op_i);

    logic [DATA_W-1:0] ar_res, lg_res, sh_res;
    logic ar_z, ar_n, ar_h, ar_c, lg_z, sh_c, w_h, w_c;

    alu8_arith #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_arith (
        .op(op), .a(a_i), .b(b_i), .cin(flags_i[FC]),
        .res(ar_res), .z(ar_z), .n(ar_n), .h(ar_h), .c(ar_c)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .op(op), .a(a_i), .b(b_i), .res(lg_res), .z(lg_z)
    );

    alu8_shift #(.DATA_W(DATA_W)) u_shift (
        .op(op), .a(a_i), .cin(flags_i[FC]), .res(sh_res), .cout(sh_c)
    );

    alu8_wide_add #(.WIDE_W(WIDE_W), .NIB_W(NIB_W)) u_wide (
        .wa(wa_i), .wb(wb_i), .sum(wres_o), .h(w_h), .c(w_c)
    );

    always_comb begin
        res_o   = a_i;
        flags_o = flags_i;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                res_o   = ar_res;
                flags_o = {ar_z, ar_n, ar_h, ar_c};
            end
            OP_CMP: flags_o = {ar_z, ar_n, ar_h, ar_c};
            OP_INC, OP_DEC: begin
                res_o   = ar_res;
                flags_o = {ar_z, ar_n, ar_h, flags_i[FC]};
            end
            OP_AND: begin
                res_o   = lg_res;
                flags_o = {lg_z, 1'b0, 1'b1, 1'b0};
            end
            OP_OR, OP_XOR: begin
                res_o   = lg_res;
                flags_o = {lg_z, 1'b0, 1'b0, 1'b0};
            end
            OP_CPL: begin
                res_o   = lg_res;
                flags_o = {flags_i[FZ], 1'b1, 1'b1, flags_i[FC]};
            end
            OP_RLC, OP_RRC, OP_RLT, OP_RRT: begin
                res_o   = sh_res;
                flags_o = {1'b0, 1'b0, 1'b0, sh_c};
            end
            OP_SCF:  flags_o = {flags_i[FZ], 1'b0, 1'b0, 1'b1};
            OP_CCF:  flags_o = {flags_i[FZ], 1'b0, 1'b0, ~flags_i[FC]};
            OP_WADD: flags_o = {flags_i[FZ], 1'b0, w_h, w_c};
            default: begin
                res_o   = a_i;
                flags_o = flags_i;
            end
        endcase
    end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WIDE_W = 16
) (
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [DATA_W-1:0] res_o,
    input logic [FLAG_W-1:0] flags_o
);
    always_comb begin
        if (op_i == OP_AND)
            a_r5_and_forced: assert (flags_o[FH] && !flags_o[FN] && !flags_o[FC])
                else $error("AND flag forcing wrong");
        if (op_i == OP_CMP)
            a_r4_cmp_keeps_acc: assert (res_o == a_i)
                else $error("CMP altered result");
        if (op_i == OP_INC || op_i == OP_DEC)
            a_r6_incdec_keep_c: assert (flags_o[FC] == flags_i[FC])
                else $error("INC/DEC altered carry");
        if (op_i >= OP_RLC && op_i <= OP_RRT)
            a_r7_rot_clear: assert (flags_o[3:1] == 3'b000)
                else $error("rotate left Z/N/H set");
        if (op_i == OP_WADD)
            a_r11_wadd_keep_z: assert (flags_o[FZ] == flags_i[FZ] && res_o == a_i)
                else $error("wide add touched Z or result");
        if (op_i > OP_WADD)
            a_r12_unused_inert: assert (flags_o == flags_i && res_o == a_i)
                else $error("unused code had effect");
    end
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_chk (
    .op_i(op_i), .a_i(a_i), .flags_i(flags_i), .res_o(res_o), .flags_o(flags_o)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0]  res;
        logic [15:0] wres;
        logic [3:0]  flags;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic [7:0]  a_i = '0, b_i = '0;
    logic [15:0] wa_i = '0, wb_i = '0;
    logic [3:0]  flags_i = '0;
    logic [7:0]  res_o;
    logic [15:0] wres_o;
    logic [3:0]  flags_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core u_dut (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .wa_i(wa_i), .wb_i(wb_i),
        .flags_i(flags_i), .res_o(res_o), .wres_o(wres_o), .flags_o(flags_o)
    );

    // Reference model built from the requirement text with integer math.
    function automatic exp_t model(int op, int a, int b, int wa, int wb, logic [3:0] f);
        exp_t e;
        int z = f[3], n = f[2], h = f[1], c = f[0];
        int r = a, ci, t;
        string tg;
        ci = c;
        tg = "R12";
        case (op)
            0, 1: begin
                t = (op == 1) ? ci : 0;
                r = (a + b + t) % 256; c = (a + b + t) > 255;
                h = ((a % 16) + (b % 16) + t) > 15; n = 0; z = (r == 0);
                tg = "R2";
            end
            2, 3, 4: begin
                t = (op == 3) ? ci : 0;
                r = (a - b - t + 512) % 256; c = a < (b + t);
                h = (a % 16) < ((b % 16) + t); n = 1; z = (r == 0);
                if (op == 4) begin r = a; tg = "R4"; end else tg = "R3";
            end
            5, 6, 7: begin
                r = (op == 5) ? (a & b) : (op == 6) ? (a | b) : (a ^ b);
                z = (r == 0); n = 0; c = 0; h = (op == 5);
                tg = "R5";
            end
            8: begin r = (a + 1) % 256; z = (r == 0); n = 0; h = (a % 16) == 15; tg = "R6"; end
            9: begin r = (a + 255) % 256; z = (r == 0); n = 1; h = (a % 16) == 0; tg = "R6"; end
            10: begin c = a / 128; r = (a * 2) % 256 + c; z = 0; n = 0; h = 0; tg = "R7"; end
            11: begin c = a % 2; r = a / 2 + c * 128; z = 0; n = 0; h = 0; tg = "R7"; end
            12: begin r = (a * 2) % 256 + ci; c = a / 128; z = 0; n = 0; h = 0; tg = "R8"; end
            13: begin r = a / 2 + ci * 128; c = a % 2; z = 0; n = 0; h = 0; tg = "R8"; end
            14: begin r = 255 - a; n = 1; h = 1; tg = "R9"; end
            15: begin c = 1; n = 0; h = 0; tg = "R10"; end
            16: begin c = 1 - ci; n = 0; h = 0; tg = "R10"; end
            17: begin
                n = 0; h = ((wa % 4096) + (wb % 4096)) > 4095;
                c = (wa + wb) > 65535; tg = "R11";
            end
            default: ;
        endcase
        e.res = r[7:0];
        e.wres = 16'((wa + wb) % 65536);
        e.flags = {z[0], n[0], h[0], c[0]};
        e.tag = tg;
        return e;
    endfunction

    task automatic drive(input int op, input int a, input int b, input int wa,
                         input int wb, input logic [3:0] f);
        @(posedge clk);
        op_i = 5'(op); a_i = 8'(a); b_i = 8'(b);
        wa_i = 16'(wa); wb_i = 16'(wb); flags_i = f;
        sb_q.push_back(model(op, a, b, wa, wb, f));
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Monitor: compares one scoreboard item per cycle away from the driving edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (res_o !== e.res || wres_o !== e.wres || flags_o !== e.flags) begin
                    n_fail++;
                    $display("FAIL %s op=%0d a=%02h b=%02h fin=%b: res %02h wres %04h flags %b, expected res %02h wres %04h flags %b",
                             e.tag, op_i, a_i, b_i, flags_i, res_o, wres_o, flags_o,
                             e.res, e.wres, e.flags);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run incomplete, expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: all-zero inputs after reset: ADD 0+0 gives zero flag only
        drive(0, 8'h00, 8'h00, 0, 0, 4'b0000);
        // R2: nibble carry without byte carry, full wrap, ADC with carry in
        drive(0, 8'h0F, 8'h01, 0, 0, 4'b0000);
        drive(0, 8'hFF, 8'h01, 0, 0, 4'b0000);
        drive(1, 8'hFE, 8'h01, 0, 0, 4'b0001);
        drive(1, 8'h10, 8'h20, 0, 0, 4'b0000);
        // R3: equal operands, borrow, SBC borrow with 0xFF plus carry
        drive(2, 8'h42, 8'h42, 0, 0, 4'b0001);
        drive(2, 8'h10, 8'h01, 0, 0, 4'b0000);
        drive(3, 8'h00, 8'hFF, 0, 0, 4'b0001);
        // R4: compare keeps accumulator
        drive(4, 8'h05, 8'h09, 0, 0, 4'b0000);
        drive(4, 8'h33, 8'h33, 0, 0, 4'b0000);
        // R5: logic flag forcing
        drive(5, 8'hF0, 8'h0F, 0, 0, 4'b0111);
        drive(6, 8'h00, 8'h00, 0, 0, 4'b0111);
        drive(7, 8'hAA, 8'hAA, 0, 0, 4'b1111);
        // R6: inc/dec at nibble boundaries, carry passes through
        drive(8, 8'hFF, 8'h00, 0, 0, 4'b0001);
        drive(9, 8'h10, 8'h00, 0, 0, 4'b0000);
        drive(9, 8'h01, 8'h00, 0, 0, 4'b0001);
        // R7 and R8: alternating patterns against both carry values
        drive(10, 8'h81, 0, 0, 0, 4'b1110);
        drive(11, 8'h01, 0, 0, 0, 4'b0000);
        drive(12, 8'h55, 0, 0, 0, 4'b0001);
        drive(13, 8'hAA, 0, 0, 0, 4'b0001);
        drive(12, 8'h80, 0, 0, 0, 4'b0000);
        // R9 and R10
        drive(14, 8'h5A, 0, 0, 0, 4'b1001);
        drive(15, 8'h12, 0, 0, 0, 4'b1110);
        drive(16, 8'h12, 0, 0, 0, 4'b0111);
        // R11: bit-11 carry and bit-15 carry
        drive(17, 8'h77, 0, 16'h0FFF, 16'h0001, 4'b1100);
        drive(17, 8'h77, 0, 16'hFFFF, 16'h0001, 4'b0010);
        // R12: unused codes inert
        drive(18, 8'h3C, 8'hFF, 0, 0, 4'b1010);
        drive(31, 8'h00, 8'h01, 0, 0, 4'b0101);
        // Randomised sweep of every code with both carry values
        for (int k = 0; k < 12; k++) begin
            for (int op = 0; op < 32; op++) begin
                drive(op, int'($urandom_range(255)), int'($urandom_range(255)),
                      int'($urandom_range(65535)), int'($urandom_range(65535)),
                      4'($urandom_range(15)));
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        summary();
    end
endmodule